// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address by walking page tables held in memory. A request carries the virtual address, the access kind (read, write, instruction fetch) and the privilege of the requester. The walker first reads a descriptor from a context table. It then descends through up to three levels of page tables, issuing one memory read at a time. A walk ends when it finds a terminal entry (a page table entry) or a fault.

On a terminal entry the walker checks the requested access against the entry's 3-bit access-control field. If the entry's referenced bit or modified bit needs updating, it writes the entry back. It then returns the physical address, a size code for the mapped region and the rights granted. On any fault it returns a single fault word that carries both the walk level and the fault type. When translation is off, addresses pass straight through, and an instruction fetch in boot mode is steered into a boot ROM window. Fault status capture, TLB storage and trap handling belong to the surrounding MMU.

Top module: `ptw_walker`

## Requirements
- R1: The first memory read of an enabled walk is at address `cfg_ctx_ptr*16 + cfg_ctx*4`.
- R2: Bits 1:0 of every fetched word give its kind (0 invalid, 1 table descriptor, 2 page entry, 3 reserved). A descriptor fetched at level L (0 for the context table, up to 2) leads to a read at level L+1. That read's address is `(word & ~3) * 16 + index*4`, where the index is VA[31:24] for level 1, VA[23:18] for level 2 and VA[17:12] for level 3.
- R3: A page entry at level 1, 2 or 3 maps 16 MB, 256 KB or 4 KB, reported on `rsp_size` as 2, 1 or 0. The physical address is `entry[31:8] * 4096` plus the VA offset inside the region (VA[23:0], VA[17:0] or VA[11:0]).
- R4: A fault word holds the level (0 to 3) in bits 9:8 and the type in bits 4:2, with every other bit zero. An invalid word gives type 1. A word of zero means success.
- R5: A reserved word, a page entry in the context table (level 0), or a table descriptor at level 3 gives fault type 4 at that level.
- R6: The access index is {write, fetch, supervisor}. A user access to an entry with access field 6 or 7 is a privilege fault (type 3). Otherwise, a missing right is a protection fault (type 2). Write needs W, fetch needs X, and a plain read needs R. The rights for each access field are listed in R9. An access fault reports the level of the entry. On any fault, `rsp_pa`, `rsp_size` and `rsp_perm` are zero.
- R7: With `cfg_nofault` set, an access fault on a user access is suppressed and the translation completes normally. A supervisor access still faults.
- R8: On a successful page entry, the entry is written back to the same address with bit 5 (referenced) set, and with bit 6 (modified) also set on a write. The write-back happens only when this changes the word. A faulting walk never writes.
- R9: `rsp_perm` is {R, W, X} (bit 2 read, bit 1 write, bit 0 execute). The access field gives these rights:

  | Access field | Supervisor | User |
  |---|---|---|
  | 0 | R | R |
  | 1 | RW | RW |
  | 2 | RX | RX |
  | 3 | RWX | RWX |
  | 4 | X | X |
  | 5 | RW | R |
  | 6 | RX | none |
  | 7 | RWX | none |

  W is removed whenever the modified bit of the final entry is clear.
- R10: With `cfg_enable` low, no memory access is made and the response comes in the cycle after acceptance with size 0 and no fault. The physical address is the zero-extended VA with rights RWX. When `cfg_boot` is set and the request is a fetch, the address is instead `cfg_rom_base | VA[18:0]` with rights RX.
- R11: `req_ready` is high only when the walker is idle, and a request is accepted when `req_valid` and `req_ready` are both high. A memory request stays valid with a stable address, direction and data until `mem_req_ready`. Each read waits for its `mem_rsp_valid` before anything else is issued. `rsp_valid` is a one-cycle pulse, after which the walker is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_super | input | 1 | Access is from supervisor mode |
| cfg_enable | input | 1 | Translation enabled |
| cfg_boot | input | 1 | Boot mode: fetches go to the ROM window when translation is off |
| cfg_nofault | input | 1 | Suppress access faults of user accesses |
| cfg_ctx_ptr | input | 32 | Context table pointer (address / 16) |
| cfg_ctx | input | CTX_W | Context number |
| cfg_rom_base | input | PA_W | Boot ROM base address |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | PA_W | Memory byte address |
| mem_req_wdata | output | 32 | Write-back word |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Read data |
| rsp_valid | output | 1 | Result pulse |
| rsp_pa | output | PA_W | Physical address |
| rsp_size | output | 2 | 0 4 KB, 1 256 KB, 2 16 MB |
| rsp_perm | output | 3 | Granted rights {R,W,X} |
| rsp_fault | output | 10 | Fault word, zero on success |

## Verification
The hardest case to reach is an entry that is both terminal and updated while the memory stalls. This is where a write-back has to be held stable across cycles without ready, and its data must match what the following walk reads back. The bench gets there by preloading its memory model with page entries whose referenced and modified bits are clear. It then sweeps all 64 pairs of access index and access field with the no-fault control set. During those sweeps it throttles memory ready in a fixed pattern, so that reads and write-backs meet stalls in different phases.

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker #(
  parameter int PA_W  = 36,
  parameter int CTX_W = 8,
  parameter int ROM_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_va,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic              req_super,
  input  logic              cfg_enable,
  input  logic              cfg_boot,
  input  logic              cfg_nofault,
  input  logic [31:0]       cfg_ctx_ptr,
  input  logic [CTX_W-1:0]  cfg_ctx,
  input  logic [PA_W-1:0]   cfg_rom_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [PA_W-1:0]   mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [1:0]        rsp_size,
  output logic [2:0]        rsp_perm,
  output logic [9:0]        rsp_fault
);

  localparam logic [2:0] FT_INV  = 3'd1;
  localparam logic [2:0] FT_PROT = 3'd2;
  localparam logic [2:0] FT_PRIV = 3'd3;
  localparam logic [2:0] FT_KIND = 3'd4;
  localparam logic [2:0] P_RWX   = 3'b111;
  localparam logic [2:0] P_RX    = 3'b101;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WAIT, S_WB, S_DONE} st_t;
  st_t state;

  logic [31:0]     va_q, entry_q;
  logic            wr_q, fx_q, su_q, nf_q;
  logic [1:0]      lvl_q;
  logic [PA_W-1:0] addr_q, pa_q;
  logic [1:0]      size_q;
  logic [2:0]      perm_q;
  logic [9:0]      fault_q;

  logic [1:0]      kind;
  logic [2:0]      acc, base, need, grant;
  logic            user, priv, prot, suppress;
  logic [31:0]     upd;
  logic [7:0]      idx;
  logic [23:0]     offs;
  logic [PA_W-1:0] next_addr, leaf_pa;

  assign kind     = mem_rsp_data[1:0];
  assign acc      = mem_rsp_data[4:2];
  assign user     = ~su_q;
  assign need     = {~wr_q & ~fx_q, wr_q, fx_q};
  assign priv     = user & acc[2] & acc[1];
  assign prot     = |(need & ~base);
  assign suppress = nf_q & user;
  assign upd      = mem_rsp_data | 32'h20 | {25'd0, wr_q, 6'd0};
  assign grant    = base & {1'b1, upd[6], 1'b1};

  always_comb begin
    case (acc)
      3'd0:    base = 3'b100;
      3'd1:    base = 3'b110;
      3'd2:    base = 3'b101;
      3'd3:    base = 3'b111;
      3'd4:    base = 3'b001;
      3'd5:    base = user ? 3'b100 : 3'b110;
      3'd6:    base = user ? 3'b000 : 3'b101;
      default: base = user ? 3'b000 : 3'b111;
    endcase
  end

  always_comb begin
    case (lvl_q)
      2'd0:    idx = va_q[31:24];
      2'd1:    idx = {2'b00, va_q[23:18]};
      default: idx = {2'b00, va_q[17:12]};
    endcase
    case (lvl_q)
      2'd1:    offs = va_q[23:0];
      2'd2:    offs = {6'd0, va_q[17:0]};
      default: offs = {12'd0, va_q[11:0]};
    endcase
  end

  assign next_addr = PA_W'({mem_rsp_data[31:2], 6'd0}) + PA_W'({idx, 2'b00});
  assign leaf_pa   = PA_W'({mem_rsp_data[31:8], 12'd0}) + PA_W'(offs);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      va_q    <= '0;
      entry_q <= '0;
      wr_q    <= 1'b0;
      fx_q    <= 1'b0;
      su_q    <= 1'b0;
      nf_q    <= 1'b0;
      lvl_q   <= '0;
      addr_q  <= '0;
      pa_q    <= '0;
      size_q  <= '0;
      perm_q  <= '0;
      fault_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q    <= req_va;
          wr_q    <= req_write;
          fx_q    <= req_fetch;
          su_q    <= req_super;
          nf_q    <= cfg_nofault;
          lvl_q   <= '0;
          pa_q    <= '0;
          size_q  <= '0;
          perm_q  <= '0;
          fault_q <= '0;
          if (!cfg_enable) begin
            if (cfg_boot && req_fetch) begin
              pa_q   <= cfg_rom_base | PA_W'(req_va[ROM_W-1:0]);
              perm_q <= P_RX;
            end else begin
              pa_q   <= PA_W'(req_va);
              perm_q <= P_RWX;
            end
            state <= S_DONE;
          end else begin
            addr_q <= PA_W'({cfg_ctx_ptr, 4'd0}) + PA_W'({cfg_ctx, 2'b00});
            state  <= S_RD;
          end
        end
        S_RD: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          state <= S_DONE;
          case (kind)
            2'd0: fault_q <= {lvl_q, 3'd0, FT_INV, 2'b00};
            2'd1: begin
              if (lvl_q == 2'd3) fault_q <= {lvl_q, 3'd0, FT_KIND, 2'b00};
              else begin
                addr_q <= next_addr;
                lvl_q  <= lvl_q + 2'd1;
                state  <= S_RD;
              end
            end
            2'd2: begin
              if (lvl_q == 2'd0) fault_q <= {lvl_q, 3'd0, FT_KIND, 2'b00};
              else if ((priv || prot) && !suppress)
                fault_q <= {lvl_q, 3'd0, priv ? FT_PRIV : FT_PROT, 2'b00};
              else begin
                pa_q    <= leaf_pa;
                size_q  <= 2'd3 - lvl_q;
                perm_q  <= grant;
                entry_q <= upd;
                if (upd != mem_rsp_data) state <= S_WB;
              end
            end
            default: fault_q <= {lvl_q, 3'd0, FT_KIND, 2'b00};
          endcase
        end
        S_WB: if (mem_req_ready) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_RD) || (state == S_WB);
  assign mem_req_we    = (state == S_WB);
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = entry_q;
  assign rsp_valid     = (state == S_DONE);
  assign rsp_pa        = pa_q;
  assign rsp_size      = size_q;
  assign rsp_perm      = perm_q;
  assign rsp_fault     = fault_q;

endmodule

// File: rtl/ptw_walker_chk.sv
`timescale 1ns/1ps
module ptw_walker_chk #(
  parameter int PA_W = 36
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic            mem_req_we,
  input logic [PA_W-1:0] mem_req_addr,
  input logic [31:0]     mem_req_wdata,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_pa,
  input logic [1:0]      rsp_size,
  input logic [2:0]      rsp_perm,
  input logic [9:0]      rsp_fault
);

  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  assert_fault_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault[1:0] == 2'b00 && rsp_fault[7:5] == 3'd0
      && (rsp_fault == 10'd0 || (rsp_fault[4:2] != 3'd0 && rsp_fault[4:2] <= 3'd4)));

  assert_fault_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 10'd0 |-> rsp_perm == 3'd0 && rsp_pa == '0 && rsp_size == 2'd0);

  assert_wb_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_wdata[5] && mem_req_wdata[1:0] == 2'b10);

endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata), .rsp_valid(rsp_valid),
  .rsp_pa(rsp_pa), .rsp_size(rsp_size), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault)
);

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
  localparam int PA_W = 36;
  localparam int CTX_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0, req_super = 1'b0;
  logic [31:0] req_va = '0;
  logic cfg_enable = 1'b0, cfg_boot = 1'b0, cfg_nofault = 1'b0;
  logic [31:0] cfg_ctx_ptr = '0;
  logic [CTX_W-1:0] cfg_ctx = '0;
  logic [PA_W-1:0] cfg_rom_base = '0;
  logic mem_req_ready = 1'b1, mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic req_ready, mem_req_valid, mem_req_we, rsp_valid;
  logic [PA_W-1:0] mem_req_addr, rsp_pa;
  logic [31:0] mem_req_wdata;
  logic [1:0] rsp_size;
  logic [2:0] rsp_perm;
  logic [9:0] rsp_fault;

  always #10 clk = ~clk;

  ptw_walker #(.PA_W(PA_W), .CTX_W(CTX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_write(req_write), .req_fetch(req_fetch), .req_super(req_super),
    .cfg_enable(cfg_enable), .cfg_boot(cfg_boot), .cfg_nofault(cfg_nofault),
    .cfg_ctx_ptr(cfg_ctx_ptr), .cfg_ctx(cfg_ctx), .cfg_rom_base(cfg_rom_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_size(rsp_size),
    .rsp_perm(rsp_perm), .rsp_fault(rsp_fault)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] mem [longint];
  longint exp_reads[$];
  bit exp_wb, seen_wb;
  longint exp_wb_addr, exp_pa, first_rd;
  logic [31:0] exp_wb_data;
  int exp_size, exp_perm, exp_fault;
  bit stall_en = 0, rsp_due = 0;
  logic [31:0] rsp_word;
  int cyc = 0;

  localparam longint L1B = 64'h20000, L2B = 64'h30000, L3B = 64'h40000;

  task automatic chk(input string tag, input longint act, input longint expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic logic [31:0] ptd(input longint b);
    return 32'((b >> 4) | 1);
  endfunction

  function automatic logic [31:0] pte(input int ppn, input int acc, input bit r, input bit m);
    return {ppn[23:0], 1'b0, m, r, acc[2:0], 2'b10};
  endfunction

  function automatic longint l1a(input logic [31:0] va);
    return L1B + longint'(va[31:24]) * 4;
  endfunction
  function automatic longint l2a(input logic [31:0] va);
    return L2B + longint'(va[23:18]) * 4;
  endfunction
  function automatic longint l3a(input logic [31:0] va);
    return L3B + longint'(va[17:12]) * 4;
  endfunction

  function automatic int acc_code(input int ix, input int acc);
    int row[8];
    case (ix)
      0: row = '{0, 0, 0, 0, 2, 0, 3, 3};
      1: row = '{0, 0, 0, 0, 2, 0, 0, 0};
      2: row = '{2, 2, 0, 0, 0, 2, 3, 3};
      3: row = '{2, 2, 0, 0, 0, 2, 0, 0};
      4: row = '{2, 0, 2, 0, 2, 2, 3, 3};
      5: row = '{2, 0, 2, 0, 2, 0, 2, 0};
      6: row = '{2, 2, 2, 0, 2, 2, 3, 3};
      default: row = '{2, 2, 2, 0, 2, 2, 2, 0};
    endcase
    return row[acc];
  endfunction

  function automatic int rights(input bit usr, input int acc);
    case (acc)
      0: return 4;
      1: return 6;
      2: return 5;
      3: return 7;
      4: return 1;
      5: return usr ? 4 : 6;
      6: return usr ? 0 : 5;
      default: return usr ? 0 : 7;
    endcase
  endfunction

  task automatic model(input logic [31:0] va, input bit w, input bit f, input bit s);
    longint a;
    logic [31:0] d, upd;
    int code, acc, ix;
    exp_reads.delete();
    exp_wb = 0; exp_pa = 0; exp_size = 0; exp_perm = 0; exp_fault = 0;
    if (!cfg_enable) begin
      if (cfg_boot && f) begin
        exp_pa = longint'(cfg_rom_base) | longint'(va & 32'h7FFFF);
        exp_perm = 5;
      end else begin
        exp_pa = longint'(va);
        exp_perm = 7;
      end
      return;
    end
    a = longint'(cfg_ctx_ptr) * 16 + longint'(cfg_ctx) * 4;
    for (int lvl = 0; lvl < 4; lvl++) begin
      exp_reads.push_back(a);
      d = mem.exists(a) ? mem[a] : 32'd0;
      if (d[1:0] == 2'd0) begin exp_fault = lvl * 256 + 4; return; end
      if (d[1:0] == 2'd3 || (d[1:0] == 2'd2 && lvl == 0) || (d[1:0] == 2'd1 && lvl == 3)) begin
        exp_fault = lvl * 256 + 16;
        return;
      end
      if (d[1:0] == 2'd1) begin
        if (lvl == 0) ix = int'(va[31:24]);
        else if (lvl == 1) ix = int'(va[23:18]);
        else ix = int'(va[17:12]);
        a = longint'(d & 32'hFFFF_FFFC) * 16 + longint'(ix) * 4;
        continue;
      end
      acc = int'(d[4:2]);
      code = acc_code({29'd0, w, f, s}, acc);
      if (code != 0 && !(cfg_nofault && !s)) begin
        exp_fault = lvl * 256 + code * 4;
        return;
      end
      upd = d | 32'h20 | (w ? 32'h40 : 32'h0);
      if (upd != d) begin exp_wb = 1; exp_wb_addr = a; exp_wb_data = upd; end
      exp_perm = rights(!s, acc);
      if (!upd[6]) exp_perm = exp_perm & 5;
      if (lvl == 1) begin exp_pa = longint'(d[31:8]) * 4096 + longint'(va[23:0]); exp_size = 2; end
      else if (lvl == 2) begin exp_pa = longint'(d[31:8]) * 4096 + longint'(va[17:0]); exp_size = 1; end
      else begin exp_pa = longint'(d[31:8]) * 4096 + longint'(va[11:0]); exp_size = 0; end
      return;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 1'b0;
    if (rsp_due) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data = rsp_word;
      rsp_due = 0;
    end
    mem_req_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (!mem_req_we) begin
        total++;
        if (exp_reads.size() == 0) begin
          bad++;
          $display("FAIL R2 unexpected read actual=%0h expected=none", mem_req_addr);
        end else begin
          if (longint'(mem_req_addr) != exp_reads[0]) begin
            bad++;
            $display("FAIL R2 read address actual=%0h expected=%0h", mem_req_addr, exp_reads[0]);
          end
          void'(exp_reads.pop_front());
        end
        if (first_rd < 0) first_rd = longint'(mem_req_addr);
        rsp_word = mem.exists(longint'(mem_req_addr)) ? mem[longint'(mem_req_addr)] : 32'd0;
        rsp_due = 1;
      end else begin
        total++;
        if (!exp_wb || longint'(mem_req_addr) != exp_wb_addr || mem_req_wdata != exp_wb_data) begin
          bad++;
          $display("FAIL R8 write-back actual=%0h:%0h expected=%0h:%0h (expected=%0d)",
                   mem_req_addr, mem_req_wdata, exp_wb_addr, exp_wb_data, exp_wb);
        end
        seen_wb = 1;
        mem[longint'(mem_req_addr)] = mem_req_wdata;
      end
    end
  end

  task automatic run(input string tag, input logic [31:0] va, input bit w, input bit f, input bit s);
    int n;
    bit busy_bad;
    model(va, w, f, s);
    seen_wb = 0;
    first_rd = -1;
    busy_bad = 0;
    chk({tag, " R11 ready when idle"}, longint'(req_ready), 1);
    req_va = va; req_write = w; req_fetch = f; req_super = s;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 200) begin
      if (req_ready) busy_bad = 1;
      @(negedge clk);
      n++;
    end
    chk({tag, " R11 response seen"}, longint'(rsp_valid), 1);
    chk({tag, " R11 not ready while busy"}, longint'(busy_bad | req_ready), 0);
    chk({tag, " pa"}, longint'(rsp_pa), exp_pa);
    chk({tag, " size"}, longint'(rsp_size), longint'(exp_size));
    chk({tag, " perm"}, longint'(rsp_perm), longint'(exp_perm));
    chk({tag, " fault"}, longint'(rsp_fault), longint'(exp_fault));
    chk({tag, " R2 all reads made"}, longint'(exp_reads.size()), 0);
    chk({tag, " R8 write-back made"}, longint'(seen_wb), longint'(exp_wb));
    if (cfg_enable)
      chk({tag, " R1 first address"}, first_rd, longint'(cfg_ctx_ptr) * 16 + longint'(cfg_ctx) * 4);
    else
      chk({tag, " R10 latency"}, longint'(n), 0);
    @(negedge clk);
    chk({tag, " R11 pulse ends"}, longint'(rsp_valid), 0);
  endtask

  initial begin
    #3000000;
    total++;
    bad++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [31:0] va;
    repeat (3) @(negedge clk);
    chk("R11 reset ready", longint'(req_ready), 1);
    chk("R11 reset rsp_valid", longint'(rsp_valid), 0);
    chk("R11 reset mem idle", longint'(mem_req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    cfg_rom_base = 36'hF_0000_0000;
    run("R10 passthrough read", 32'hCAFE_1234, 0, 0, 1);
    cfg_boot = 1'b1;
    run("R10 boot fetch", 32'hCAFE_1234, 0, 1, 0);
    chk("R10 boot pa value", longint'(rsp_pa), 64'hF_0006_1234);
    run("R10 boot data write", 32'h8765_4321, 1, 0, 0);
    cfg_boot = 1'b0;

    cfg_enable = 1'b1;
    cfg_ctx_ptr = 32'h0ABC_D000;
    cfg_ctx = 8'hA5;
    run("R1 empty context R4", 32'h0, 0, 0, 1);
    chk("R4 invalid context code", longint'(rsp_fault), 64'h004);

    cfg_ctx_ptr = 32'h0000_1000;
    cfg_ctx = 8'd3;
    va = 32'h1234_5678;
    mem[64'h1000C] = pte(24'h111, 3, 1, 1);
    run("R5 level0 entry", va, 0, 0, 1);
    chk("R5 level0 code", longint'(rsp_fault), 64'h010);
    mem[64'h1000C] = ptd(L1B);
    mem[l1a(va)] = 32'h3;
    run("R5 reserved level1", va, 0, 0, 1);
    chk("R5 reserved code", longint'(rsp_fault), 64'h110);

    mem[l1a(va)] = pte(24'hABCDE, 3, 0, 0);
    run("R3 R8 R9 level1 first", va, 0, 0, 1);
    chk("R3 16MB size", longint'(rsp_size), 2);
    chk("R9 no write before modified", longint'(rsp_perm), 5);
    run("R8 level1 second no update", va, 0, 0, 1);

    mem[l1a(va)] = ptd(L2B);
    mem[l2a(va)] = pte(24'h5_4321, 1, 1, 0);
    run("R8 R9 level2 write", va, 1, 0, 1);
    chk("R9 write granted after update", longint'(rsp_perm), 6);
    chk("R3 256KB size", longint'(rsp_size), 1);
    mem[l2a(va)] = 32'h0;
    run("R4 level2 invalid", va, 0, 0, 1);
    chk("R4 level2 code", longint'(rsp_fault), 64'h204);

    mem[l2a(va)] = ptd(L3B);
    mem[l3a(va)] = pte(24'h00_0777, 3, 1, 1);
    run("R3 level3 user read", va, 0, 0, 0);
    chk("R3 4KB pa", longint'(rsp_pa), 64'h77_7678);
    mem[l3a(va)] = ptd(64'h50000);
    run("R5 level3 descriptor", va, 0, 0, 1);
    chk("R5 level3 code", longint'(rsp_fault), 64'h310);

    for (int ix = 0; ix < 8; ix++)
      for (int acc = 0; acc < 8; acc++) begin
        mem[l3a(va)] = pte(24'h00_0900 + acc, acc, 1, 1);
        run("R6 access sweep", va, ix[2], ix[1], ix[0]);
      end
    mem[l3a(va)] = pte(24'h00_0901, 6, 1, 1);
    run("R6 user privilege", va, 0, 0, 0);
    chk("R6 privilege code", longint'(rsp_fault), 64'h30C);

    stall_en = 1;
    cfg_nofault = 1'b1;
    for (int ix = 0; ix < 8; ix++)
      for (int acc = 0; acc < 8; acc++) begin
        mem[l3a(va)] = pte(24'h00_0A00 + acc, acc, 0, 0);
        run("R7 R11 nofault stall sweep", va, ix[2], ix[1], ix[0]);
      end
    mem[l3a(va)] = pte(24'h00_0B00, 6, 0, 0);
    run("R7 user suppressed", va, 0, 0, 0);
    chk("R7 suppressed code", longint'(rsp_fault), 0);
    mem[l3a(va)] = pte(24'h00_0B01, 2, 1, 1);
    run("R7 supervisor still faults", va, 1, 0, 1);
    chk("R7 supervisor code", longint'(rsp_fault), 64'h308);
    cfg_nofault = 1'b0;

    va = 32'h0004_1FFF;
    mem[l1a(va)] = ptd(L2B);
    mem[l2a(va)] = ptd(L3B);
    mem[l3a(va)] = pte(24'hFF_FFFF, 7, 1, 0);
    run("R2 R11 stalled other index", va, 1, 0, 1);
    stall_en = 0;
    repeat (2) @(negedge clk);
    summary();
  end
endmodule